// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the hand-off point between a host processor and an embedded management controller. The host uses a plain 32-bit register bus with a byte address. It writes a command word, fills a 16-byte outbound payload area, polls a status word and reads back a 16-byte reply area. The controller side sees a one-cycle doorbell, the latched command word and the outbound payload. It writes its reply words into the inbound area and ends the command with a done strobe that carries an error flag and an 8-bit error code.

A command word is accepted only while the mailbox is idle. Acceptance sets busy and rings the doorbell. The command's own id field is mirrored into the status word, next to a fixed initiator id. If the host sets the completion-request bit in the command word, the done strobe also produces a one-cycle host interrupt pulse and sets a sticky flag in status. The host clears that flag by writing it back as one. The payload-size field of the command word is carried to the controller unchanged, so the controller knows how many payload bytes are valid.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, busy, error, the interrupt flag and the error code read as zero, both payload areas hold zeros, and neither the doorbell nor the host interrupt is asserted.
- R2: A host write to offset 0x00 while idle is accepted. From the next cycle, status bit 0 (busy) reads 1, `c_cmd` holds the written word, and `c_doorbell` is high for exactly that one cycle.
- R3: A host write to offset 0x00 while busy is ignored. It produces no doorbell, and neither `c_cmd` nor the status command id changes.
- R4: The status word at offset 0x04 is laid out as busy in bit 0, error in bit 1, interrupt flag in bit 2, zero in bit 3, command id in bits 7:4, initiator id in bits 15:8 and error code in bits 23:16, with zeros in bits 31:24. The command id is a copy of bits 15:12 of the accepted command word. The initiator id is the parameter `HOST_ID` (0x42 by default).
- R5: A done strobe while busy clears busy in the next cycle and latches `c_err` into status bit 1 and `c_err_code` into bits 23:16. A done strobe while idle changes nothing.
- R6: If bit 8 of the accepted command word is 1, the done strobe gives a one-cycle `h_irq` pulse in the following cycle and sets status bit 2. If bit 8 is 0, neither happens.
- R7: A host write to offset 0x04 with data bit 2 set clears the interrupt flag. A write there with bit 2 clear leaves the flag as it was.
- R8: The outbound area at offsets 0x80 to 0x8F takes host writes, one byte lane per `h_wstrb` bit. The controller reads it by word index through `c_obuf_idx`. Host reads of this area return zero.
- R9: The controller writes the inbound area, offsets 0x90 to 0x9F, by word index. A host read there with `h_byte` low returns the addressed 32-bit word. With `h_byte` high it returns the addressed byte in bits 7:0, with all other bits zero.
- R10: The command register reads as zero. Accepting a new command clears the previous error flag and error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_wstrb | input | 4 | Host byte-lane enables for the outbound area |
| h_byte | input | 1 | Host read width: 1 selects a single byte |
| h_rdata | output | 32 | Host read data, combinational on `h_addr` |
| h_irq | output | 1 | One-cycle command-completion pulse to the host |
| c_doorbell | output | 1 | One-cycle new-command pulse to the controller |
| c_cmd | output | 32 | Accepted command word |
| c_obuf_idx | input | IDX_W | Controller read index into the outbound area |
| c_obuf_data | output | 32 | Outbound word at `c_obuf_idx` |
| c_ibuf_we | input | 1 | Controller write enable for the inbound area |
| c_ibuf_idx | input | IDX_W | Controller write index into the inbound area |
| c_ibuf_data | input | 32 | Controller write data |
| c_done | input | 1 | Controller finished the current command |
| c_err | input | 1 | Error flag that accompanies `c_done` |
| c_err_code | input | 8 | Error code that accompanies `c_done` |

## Verification
The command path is run three ways: with the completion-request bit set, with it clear, and with a second command word written while the first is still pending. A scoreboard pairs each expected doorbell and interrupt with the pulse that actually appears. This separates accepted commands from ignored ones, and requested interrupts from spurious ones. The done strobe is given once with no error, once with an error code, and once while idle, so a latch that fires in the wrong state shows up in the status word. The payload areas are tried with partial byte strobes and with both byte and word reads at several lanes, which exposes lane or index swaps.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int              BUF_BYTES = 16,
  parameter int              ADDR_W    = 8,
  parameter logic [7:0]      HOST_ID   = 8'h42,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h00,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h04,
  parameter logic [ADDR_W-1:0] OBUF_OFS = 'h80,
  parameter logic [ADDR_W-1:0] IBUF_OFS = 'h90,
  localparam int             NWORDS    = BUF_BYTES / 4,
  localparam int             IDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  input  logic [3:0]        h_wstrb,
  input  logic              h_byte,
  output logic [31:0]       h_rdata,
  output logic              h_irq,
  output logic              c_doorbell,
  output logic [31:0]       c_cmd,
  input  logic [IDX_W-1:0]  c_obuf_idx,
  output logic [31:0]       c_obuf_data,
  input  logic              c_ibuf_we,
  input  logic [IDX_W-1:0]  c_ibuf_idx,
  input  logic [31:0]       c_ibuf_data,
  input  logic              c_done,
  input  logic              c_err,
  input  logic [7:0]        c_err_code
);
  localparam int IOC_BIT = 8;
  localparam int ACK_BIT = 2;
  localparam logic [ADDR_W:0] OBUF_END = {1'b0, OBUF_OFS} + (ADDR_W+1)'(BUF_BYTES);
  localparam logic [ADDR_W:0] IBUF_END = {1'b0, IBUF_OFS} + (ADDR_W+1)'(BUF_BYTES);

  logic [31:0] obuf [NWORDS];
  logic [31:0] ibuf [NWORDS];
  logic [31:0] cmd_q;
  logic [7:0]  err_code;
  logic        busy, err, irq_flag, db_q, irq_q;

  logic hit_cmd, hit_stat, in_obuf, in_ibuf, accept, finish, ack;
  logic [IDX_W-1:0] o_idx, i_idx;
  logic [1:0] lane;
  logic [31:0] status, iword;

  assign hit_cmd  = h_addr == CMD_OFS;
  assign hit_stat = h_addr == STAT_OFS;
  assign in_obuf  = ({1'b0, h_addr} >= {1'b0, OBUF_OFS}) && ({1'b0, h_addr} < OBUF_END);
  assign in_ibuf  = ({1'b0, h_addr} >= {1'b0, IBUF_OFS}) && ({1'b0, h_addr} < IBUF_END);
  assign o_idx    = IDX_W'((h_addr - OBUF_OFS) >> 2);
  assign i_idx    = IDX_W'((h_addr - IBUF_OFS) >> 2);
  assign lane     = 2'(h_addr - IBUF_OFS);

  assign accept = h_wr && hit_cmd && !busy;
  assign finish = busy && c_done;
  assign ack    = h_wr && hit_stat && h_wdata[ACK_BIT];

  assign status = {8'h00, err_code, HOST_ID, cmd_q[15:12], 1'b0, irq_flag, err, busy};
  assign iword  = ibuf[i_idx];

  always_comb begin
    h_rdata = '0;
    if (hit_stat)
      h_rdata = status;
    else if (in_ibuf)
      h_rdata = h_byte ? {24'h0, iword[8*lane +: 8]} : iword;
  end

  assign c_obuf_data = obuf[c_obuf_idx];
  assign c_cmd       = cmd_q;
  assign c_doorbell  = db_q;
  assign h_irq       = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
      irq_flag <= 1'b0;
      cmd_q    <= '0;
      db_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      db_q  <= accept;
      irq_q <= 1'b0;
      if (ack) irq_flag <= 1'b0;
      if (accept) begin
        cmd_q    <= h_wdata;
        busy     <= 1'b1;
        err      <= 1'b0;
        err_code <= '0;
      end else if (finish) begin
        busy     <= 1'b0;
        err      <= c_err;
        err_code <= c_err_code;
        if (cmd_q[IOC_BIT]) begin
          irq_q    <= 1'b1;
          irq_flag <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORDS; w++) begin
        obuf[w] <= '0;
        ibuf[w] <= '0;
      end
    end else begin
      if (h_wr && in_obuf)
        for (int b = 0; b < 4; b++)
          if (h_wstrb[b]) obuf[o_idx][8*b +: 8] <= h_wdata[8*b +: 8];
      if (c_ibuf_we) ibuf[c_ibuf_idx] <= c_ibuf_data;
    end
  end

  assert_doorbell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && c_doorbell && c_cmd == $past(h_wdata));
  assert_doorbell_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_doorbell |=> !c_doorbell);
  assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr && hit_cmd && busy |=> !c_doorbell && $stable(c_cmd));
  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !c_done |=> busy);
  assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && c_done |=> !busy && err == $past(c_err) && err_code == $past(c_err_code));
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |=> !h_irq);
  assert_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && c_done && c_cmd[IOC_BIT]) |=> !h_irq);
  assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !(busy && c_done) |=> !irq_flag);
endmodule

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [3:0]  h_wstrb = '0;
  logic        h_byte = 1'b0;
  logic [31:0] h_rdata;
  logic        h_irq, c_doorbell;
  logic [31:0] c_cmd, c_obuf_data;
  logic [1:0]  c_obuf_idx = '0;
  logic        c_ibuf_we = 1'b0;
  logic [1:0]  c_ibuf_idx = '0;
  logic [31:0] c_ibuf_data = '0;
  logic        c_done = 1'b0, c_err = 1'b0;
  logic [7:0]  c_err_code = '0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_cmd_q [$];
  int          exp_irq_q [$];
  logic        db_prev = 1'b0, irq_prev = 1'b0;
  logic [31:0] rd, e;

  always #4 clk = ~clk;

  ipc_mailbox dut (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_wstrb(h_wstrb), .h_byte(h_byte), .h_rdata(h_rdata), .h_irq(h_irq),
    .c_doorbell(c_doorbell), .c_cmd(c_cmd), .c_obuf_idx(c_obuf_idx),
    .c_obuf_data(c_obuf_data), .c_ibuf_we(c_ibuf_we), .c_ibuf_idx(c_ibuf_idx),
    .c_ibuf_data(c_ibuf_data), .c_done(c_done), .c_err(c_err), .c_err_code(c_err_code)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    h_wr = 1'b1; h_addr = a; h_wdata = d; h_wstrb = s;
    @(negedge clk);
    h_wr = 1'b0; h_wstrb = '0;
  endtask

  task automatic send_cmd(input logic [31:0] d);
    exp_cmd_q.push_back(d);
    host_write(8'h00, d, 4'hF);
  endtask

  task automatic host_read(input logic [7:0] a, input logic b, output logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_byte = b;
    #1 d = h_rdata;
  endtask

  task automatic ctl_ibuf(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk);
    c_ibuf_we = 1'b1; c_ibuf_idx = i; c_ibuf_data = d;
    @(negedge clk);
    c_ibuf_we = 1'b0;
  endtask

  task automatic ctl_done(input logic er, input logic [7:0] code, input logic want_irq);
    if (want_irq) exp_irq_q.push_back(1);
    @(negedge clk);
    c_done = 1'b1; c_err = er; c_err_code = code;
    @(negedge clk);
    c_done = 1'b0; c_err = 1'b0; c_err_code = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (c_doorbell) begin
        if (exp_cmd_q.size() == 0) check("R3 doorbell on ignored write", 32'h1, 32'h0);
        else begin
          e = exp_cmd_q.pop_front();
          check("R2 doorbell command word", c_cmd, e);
        end
        if (db_prev) check("R2 doorbell width", 32'h2, 32'h1);
      end
      if (h_irq) begin
        if (exp_irq_q.size() == 0) check("R6 unrequested interrupt", 32'h1, 32'h0);
        else void'(exp_irq_q.pop_front());
        if (irq_prev) check("R6 interrupt width", 32'h2, 32'h1);
      end
      db_prev  = c_doorbell;
      irq_prev = h_irq;
    end
  end

  initial begin
    repeat (25000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    host_read(8'h04, 1'b0, rd); check("R1 status after reset", rd, 32'h0000_4200);
    host_read(8'h90, 1'b0, rd); check("R1 inbound after reset", rd, 32'h0);
    c_obuf_idx = 2'd2; #1 check("R1 outbound after reset", c_obuf_data, 32'h0);
    check("R1 irq and doorbell idle", {31'h0, h_irq | c_doorbell}, 32'h0);

    host_write(8'h80, 32'h4433_2211, 4'hF);
    host_write(8'h84, 32'hAABB_CCDD, 4'b0101);
    c_obuf_idx = 2'd0; #1 check("R8 outbound word 0", c_obuf_data, 32'h4433_2211);
    c_obuf_idx = 2'd1; #1 check("R8 outbound lanes", c_obuf_data, 32'h00BB_00DD);
    host_read(8'h80, 1'b0, rd); check("R8 outbound not readable", rd, 32'h0);

    send_cmd(32'h0004_513A);
    host_read(8'h04, 1'b0, rd); check("R2 R4 status while busy", rd, 32'h0000_4251);
    check("R2 command word to controller", c_cmd, 32'h0004_513A);

    host_write(8'h00, 32'h0000_7077, 4'hF);
    check("R3 command word kept", c_cmd, 32'h0004_513A);
    host_read(8'h04, 1'b0, rd); check("R3 status id kept", rd, 32'h0000_4251);
    repeat (3) @(negedge clk);
    host_read(8'h04, 1'b0, rd); check("R5 busy held without done", rd, 32'h0000_4251);

    ctl_ibuf(2'd0, 32'h1122_3344);
    ctl_ibuf(2'd3, 32'hDEAD_BEEF);
    ctl_done(1'b0, 8'h00, 1'b1);
    host_read(8'h04, 1'b0, rd); check("R5 R6 status after done", rd, 32'h0000_4254);

    host_read(8'h90, 1'b0, rd); check("R9 word read 0", rd, 32'h1122_3344);
    host_read(8'h91, 1'b1, rd); check("R9 byte read lane 1", rd, 32'h0000_0033);
    host_read(8'h9F, 1'b1, rd); check("R9 byte read lane 3", rd, 32'h0000_00DE);
    host_read(8'h9C, 1'b0, rd); check("R9 word read 3", rd, 32'hDEAD_BEEF);

    host_write(8'h04, 32'hFFFF_FFFB, 4'hF);
    host_read(8'h04, 1'b0, rd); check("R7 write without ack bit", rd, 32'h0000_4254);
    host_write(8'h04, 32'h0000_0004, 4'hF);
    host_read(8'h04, 1'b0, rd); check("R7 ack clears flag", rd, 32'h0000_4250);

    send_cmd(32'h0000_A0C1);
    host_read(8'h04, 1'b0, rd); check("R4 second command id", rd, 32'h0000_42A1);
    ctl_done(1'b1, 8'h5E, 1'b0);
    host_read(8'h04, 1'b0, rd); check("R5 R6 error latched, no flag", rd, 32'h005E_42A2);

    ctl_done(1'b0, 8'h11, 1'b0);
    host_read(8'h04, 1'b0, rd); check("R5 done while idle ignored", rd, 32'h005E_42A2);

    host_read(8'h00, 1'b0, rd); check("R10 command reads zero", rd, 32'h0);
    send_cmd(32'h0000_1105);
    host_read(8'h04, 1'b0, rd); check("R10 new command clears error", rd, 32'h0000_4211);
    ctl_done(1'b0, 8'h00, 1'b1);
    host_read(8'h04, 1'b0, rd); check("R6 second interrupt flag", rd, 32'h0000_4214);

    repeat (2) @(negedge clk);
    check("R2 all doorbells seen", exp_cmd_q.size(), 32'h0);
    check("R6 all interrupts seen", exp_irq_q.size(), 32'h0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule